// File: doc/BRIEF.md
# Two-Digit Decimal Up/Down Counter with Step Select

This block is a synchronous decimal counter. It stores its value as packed BCD digits, two by default, so the value runs from 00 to 99. Each cycle in which the count-enable input is high is one count event. A count event moves the value up or down, as the direction input selects. A step-select input picks a step of one or two.

A step of two is built from two single-unit steppers in series. The second stepper is active only when the step-select input is high and the stored value is even. As a result an odd value is first brought to the next even value in the counting direction, and even values then move in pairs. A one-cycle wrap flag marks every event that crosses the modulus boundary.

The enable pulse is expected to come from a debounced button or a slow tick. The block does no display decoding.

Top module: `bcd_step_counter`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising clock edge, the value becomes 00 and `wrap_o` becomes 0 at that edge.
- R2: Every digit field of `digits_o` (bits [3:0] hold the ones digit, bits [7:4] hold the tens digit) always holds a value from 0 to 9.
- R3: At a clock edge where `cnt_en` is low, `digits_o` keeps its value.
- R4: With `step_two` low and `dir_up` high, a count event raises the value by one at the same clock edge. A ones digit of 9 becomes 0 and carries into the tens digit.
- R5: With `step_two` low and `dir_up` low, a count event lowers the value by one. A ones digit of 0 becomes 9 and borrows from the tens digit.
- R6: In step-1 mode, counting up from 99 gives 00, and counting down from 00 gives 99.
- R7: With `step_two` high and an even value, a count event moves the value by two in the selected direction. Counting up, 98 goes to 00. Counting down, 00 goes to 98.
- R8: With `step_two` high and an odd value, a count event moves the value by one in the selected direction, so it reaches the adjacent even value. Counting up, 99 goes to 00.
- R9: `wrap_o` is high for exactly the one cycle after a count event whose step (or either half of a double step) crossed 99 to 00 or 00 to 99. At all other times it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count event when high at a clock edge |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| step_two | input | 1 | 1 = step of two, 0 = step of one |
| digits_o | output | 4*DIGITS (8) | Packed BCD value, ones digit in the low nibble |
| wrap_o | output | 1 | One-cycle flag after a wrapping event |

## Verification
A wrong carry or borrow between the digits shows at the ports on the edge of the faulty event. The tens nibble then differs from the reference, or a ones nibble shows a code above 9. A missed or spurious second step in step-2 mode shows on the next edge as an odd value, or as a value off by one. A wrong wrap decision shows in `wrap_o` one cycle after the event. Because the bench compares against its reference on every clock, each of these faults is reported within one cycle of its cause.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
   typedef logic [3:0] bcd_t;
   localparam bcd_t BCD_TOP  = 4'd9;
   localparam bcd_t BCD_ZERO = 4'd0;
endpackage

// File: rtl/bcd_digit_step.sv
module bcd_digit_step
   import bcd_cnt_pkg::*;
(
   input  bcd_t d_i,
   input  logic up_i,
   input  logic ci_i,
   output bcd_t d_o,
   output logic co_o
);
   always_comb begin
      d_o  = d_i;
      co_o = 1'b0;
      if (ci_i) begin
         if (up_i) begin
            if (d_i >= BCD_TOP) begin
               d_o  = BCD_ZERO;
               co_o = 1'b1;
            end else begin
               d_o = d_i + 4'd1;
            end
         end else begin
            if (d_i == BCD_ZERO) begin
               d_o  = BCD_TOP;
               co_o = 1'b1;
            end else begin
               d_o = d_i - 4'd1;
            end
         end
      end
   end
endmodule

// File: rtl/bcd_chain_step.sv
module bcd_chain_step
   import bcd_cnt_pkg::*;
#(
   parameter int DIGITS = 2
) (
   input  bcd_t [DIGITS-1:0] val_i,
   input  logic              en_i,
   input  logic              up_i,
   output bcd_t [DIGITS-1:0] val_o,
   output logic              wrap_o
);
   logic [DIGITS:0] ripple;
   assign ripple[0] = en_i;

   for (genvar g = 0; g < DIGITS; g++) begin : g_cell
      bcd_digit_step u_cell (
         .d_i  (val_i[g]),
         .up_i (up_i),
         .ci_i (ripple[g]),
         .d_o  (val_o[g]),
         .co_o (ripple[g+1])
      );
   end

   assign wrap_o = ripple[DIGITS];
endmodule

// File: rtl/bcd_step_counter.sv
module bcd_step_counter
   import bcd_cnt_pkg::*;
#(
   parameter int DIGITS = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  cnt_en,
   input  logic                  dir_up,
   input  logic                  step_two,
   output logic [4*DIGITS-1:0]   digits_o,
   output logic                  wrap_o
);
   localparam int VW = 4 * DIGITS;

   if (DIGITS < 1 || DIGITS > 8) begin : g_bad_digits
      $error("bcd_step_counter: DIGITS must lie in 1..8");
   end

   bcd_t [DIGITS-1:0] cur_q;
   bcd_t [DIGITS-1:0] half_v;
   bcd_t [DIGITS-1:0] full_v;
   logic              wrap_a, wrap_b, second_en, wrap_q;

   // An even value in step-2 mode takes a second unit step.
   // An odd value takes only the aligning step.
   assign second_en = step_two & ~cur_q[0][0];

   bcd_chain_step #(.DIGITS(DIGITS)) u_first (
      .val_i  (cur_q),
      .en_i   (1'b1),
      .up_i   (dir_up),
      .val_o  (half_v),
      .wrap_o (wrap_a)
   );

   bcd_chain_step #(.DIGITS(DIGITS)) u_second (
      .val_i  (half_v),
      .en_i   (second_en),
      .up_i   (dir_up),
      .val_o  (full_v),
      .wrap_o (wrap_b)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cur_q  <= '0;
         wrap_q <= 1'b0;
      end else begin
         wrap_q <= cnt_en & (wrap_a | wrap_b);
         if (cnt_en) cur_q <= full_v;
      end
   end

   assign digits_o = VW'(cur_q);
   assign wrap_o   = wrap_q;
endmodule

// File: rtl/bcd_step_counter_chk.sv
module bcd_step_counter_chk #(
   parameter int DIGITS = 2
) (
   input logic                clk,
   input logic                rst,
   input logic                cnt_en,
   input logic                dir_up,
   input logic                step_two,
   input logic [4*DIGITS-1:0] digits_o,
   input logic                wrap_o
);
   function automatic logic all_valid(input logic [4*DIGITS-1:0] v);
      logic ok;
      ok = 1'b1;
      for (int i = 0; i < DIGITS; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
      return ok;
   endfunction

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (digits_o == '0 && !wrap_o));

   assert_digits_bcd_R2: assert property (@(posedge clk) disable iff (rst)
      all_valid(digits_o));

   assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
      !cnt_en |=> $stable(digits_o));

   assert_event_moves_R4: assert property (@(posedge clk) disable iff (rst)
      cnt_en |=> !$stable(digits_o));

   assert_step2_even_R7: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && step_two) |=> (digits_o[0] == 1'b0));

   assert_wrap_after_event_R9: assert property (@(posedge clk) disable iff (rst)
      !cnt_en |=> !wrap_o);
endmodule

bind bcd_step_counter bcd_step_counter_chk #(.DIGITS(DIGITS)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .cnt_en   (cnt_en),
   .dir_up   (dir_up),
   .step_two (step_two),
   .digits_o (digits_o),
   .wrap_o   (wrap_o)
);

// File: tb/tb_bcd_step_counter.sv
module tb_bcd_step_counter;
   localparam int DIGITS = 2;
   localparam int MAXV   = 99;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cnt_en = 1'b0;
   logic dir_up = 1'b1;
   logic step_two = 1'b0;
   logic [4*DIGITS-1:0] digits_o;
   logic wrap_o;

   int checks = 0;
   int errors = 0;
   int mv = 0;
   logic mw = 1'b0;
   logic chk_on = 1'b0;
   string tag = "R1";

   always #5 clk = ~clk;

   bcd_step_counter #(.DIGITS(DIGITS)) dut (
      .clk(clk), .rst(rst), .cnt_en(cnt_en), .dir_up(dir_up),
      .step_two(step_two), .digits_o(digits_o), .wrap_o(wrap_o)
   );

   // Reference model: integer value, one or two unit steps per event
   always @(posedge clk) begin
      if (rst) begin
         mv = 0;
         mw = 1'b0;
      end else if (cnt_en) begin
         int n;
         n = (step_two && (mv % 2 == 0)) ? 2 : 1;
         mw = 1'b0;
         for (int k = 0; k < n; k++) begin
            if (dir_up) begin
               if (mv == MAXV) begin mv = 0; mw = 1'b1; end else mv = mv + 1;
            end else begin
               if (mv == 0) begin mv = MAXV; mw = 1'b1; end else mv = mv - 1;
            end
         end
      end else begin
         mw = 1'b0;
      end
   end

   function automatic logic [7:0] to_bcd(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   always @(negedge clk) begin
      if (chk_on) begin
         checks++;
         if (digits_o !== to_bcd(mv)) begin
            errors++;
            $display("FAIL %s: digits actual %h expected %h", tag, digits_o, to_bcd(mv));
         end
         checks++;
         if (wrap_o !== mw) begin
            errors++;
            $display("FAIL R9: wrap actual %b expected %b (value %0d)", wrap_o, mw, mv);
         end
         checks++;
         if (digits_o[3:0] > 4'd9 || digits_o[7:4] > 4'd9) begin
            errors++;
            $display("FAIL R2: digits actual %h expected valid BCD", digits_o);
         end
      end
   end

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic drive(input int n, input logic en, input logic up, input logic two, input string t);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tag = t; cnt_en = en; dir_up = up; step_two = two;
      end
      @(negedge clk);
      cnt_en = 1'b0;
   endtask

   task automatic do_reset;
      @(negedge clk);
      tag = "R1"; rst = 1'b1; cnt_en = 1'b0;
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      #(10 * 150000);
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_on = 1'b1;
      rst = 1'b0;
      drive(4, 1'b0, 1'b1, 1'b0, "R3");        // idle, hold at 00
      drive(105, 1'b1, 1'b1, 1'b0, "R4");      // up through 99 -> 00
      drive(3, 1'b0, 1'b0, 1'b1, "R3");
      drive(105, 1'b1, 1'b0, 1'b0, "R5");      // down through 00 -> 99
      do_reset();
      drive(1, 1'b1, 1'b0, 1'b0, "R6");        // 00 -> 99
      drive(1, 1'b1, 1'b1, 1'b0, "R6");        // 99 -> 00
      drive(55, 1'b1, 1'b1, 1'b1, "R7");       // even step-2 up, 98 -> 00
      drive(55, 1'b1, 1'b0, 1'b1, "R7");       // even step-2 down, 00 -> 98
      do_reset();
      drive(37, 1'b1, 1'b1, 1'b0, "R4");
      drive(1, 1'b1, 1'b1, 1'b1, "R8");        // 37 -> 38
      drive(1, 1'b1, 1'b1, 1'b0, "R4");        // 39
      drive(1, 1'b1, 1'b0, 1'b1, "R8");        // 39 -> 38
      do_reset();
      drive(1, 1'b1, 1'b0, 1'b0, "R6");        // 99
      drive(1, 1'b1, 1'b1, 1'b1, "R8");        // 99 -> 00 with wrap
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         tag = "R7";
         cnt_en = 1'($urandom_range(0, 2) != 0);
         dir_up = 1'($urandom_range(0, 1));
         step_two = 1'($urandom_range(0, 1));
         rst = ($urandom_range(0, 400) == 0);
         if (rst) tag = "R1";
      end
      @(negedge clk);
      rst = 1'b0; cnt_en = 1'b0;
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule